// File: doc/BRIEF.md
# Quad-Fragment Merge Buffer

This block sits after rasterization and before shading. Each incoming work item is a quad: a 2x2 pixel block at a quad screen position, a 4-bit pixel coverage mask, the ID of the triangle that produced it, and up to three IDs of triangles that share an edge with that triangle in the mesh. The block keeps a small window of pending quads. A new quad that lands on the same quad position as a pending one, covers none of its pixels, and comes from a mesh neighbour of a triangle already folded into that entry is absorbed into it. The merged entry is then shaded once instead of once per triangle.

Quads leave the window in arrival order: the oldest entry is pushed out when a quad that cannot merge arrives at a full window, and a flush input drains the window one entry per cycle. Every eligibility test is a bitwise compare or a bit select. No arithmetic is involved, so the full window is searched in one cycle. Because only mesh neighbours merge, quads from the two sides of a silhouette stay apart and edge antialiasing is kept.

Top module: `qm_merge_buf`

## Requirements
- R1: After reset the window is empty: `out_valid` is low, and a flush produces no output.
- R2: An incoming quad merges with a pending entry when all of these hold: the positions are equal, the two coverage masks have no bit in common, and one of its valid neighbour IDs is in the entry's triangle set. The entry's coverage becomes the OR of both masks, its triangle set gains the incoming ID, and no output is produced that cycle.
- R3: A quad whose coverage overlaps a pending entry's coverage in any pixel does not merge with that entry.
- R4: A quad does not merge with an entry at a different position, or with an entry whose triangle set holds none of its neighbour IDs.
- R5: The all-ones neighbour code (63 for 6-bit IDs) marks an unused slot and matches nothing, even an entry that holds triangle 63.
- R6: The window holds DEPTH (32) entries. When a quad that cannot merge arrives at a full window, the oldest entry is output in the next cycle and the new quad is stored.
- R7: With `flush` high and `in_valid` low, one entry is output per cycle, oldest first, in the next cycle, until the window is empty.
- R8: When `in_valid` and `flush` are high together, the quad is handled and nothing is drained that cycle.
- R9: Once an entry has been output it no longer takes part in merging: a later neighbour quad at its position starts a new entry.
- R10: When several entries qualify, the quad merges into the oldest one.
- R11: A quad with zero coverage is discarded: the window is unchanged and nothing is output.
- R12: Each output carries the position, the coverage mask (bit p is pixel p) and the triangle set as a 2^TRI_W-bit mask with bit n set for triangle ID n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming quad present |
| in_qx | input | POS_W | Quad column |
| in_qy | input | POS_W | Quad row |
| in_cov | input | 4 | Pixel coverage of the quad |
| in_tri | input | TRI_W | Source triangle ID |
| in_nbr | input | NBR_N*TRI_W | Neighbour IDs, slot j at bits j*TRI_W; all ones = unused |
| flush | input | 1 | Drain one entry per cycle while high |
| out_valid | output | 1 | Output quad present |
| out_qx | output | POS_W | Output quad column |
| out_qy | output | POS_W | Output quad row |
| out_cov | output | 4 | Merged coverage |
| out_tris | output | 2**TRI_W | Triangle set of the output quad |

## Verification
Every result of this block is due exactly one clock edge after the cycle that causes it. A merge, append or discard changes only internal state and shows up at the output later. An eviction or drain raises `out_valid` with its fields one edge after the triggering input. The bench applies each input on a falling edge, lets a single rising edge pass, and compares the outputs on the next falling edge against a reference queue updated for that same input. No result is therefore looked for one cycle early or late.

// File: rtl/qm_pkg.sv
package qm_pkg;
   typedef enum logic [2:0] {
      ACT_IDLE,
      ACT_DROP,
      ACT_MERGE,
      ACT_APPEND,
      ACT_EVICT,
      ACT_DRAIN
   } qm_act_e;
endpackage

// File: rtl/qm_match.sv
module qm_match #(
   parameter int POS_W  = 8,
   parameter int TRI_W  = 6,
   parameter int NBR_N  = 3,
   localparam int MASK_W = 1 << TRI_W
) (
   input  logic                   e_vld,
   input  logic [POS_W-1:0]       e_qx,
   input  logic [POS_W-1:0]       e_qy,
   input  logic [3:0]             e_cov,
   input  logic [MASK_W-1:0]      e_tris,
   input  logic [POS_W-1:0]       in_qx,
   input  logic [POS_W-1:0]       in_qy,
   input  logic [3:0]             in_cov,
   input  logic [NBR_N*TRI_W-1:0] in_nbr,
   output logic                   hit
);
   localparam logic [TRI_W-1:0] NONE = '1;
   logic [NBR_N-1:0] adj;

   for (genvar j = 0; j < NBR_N; j++) begin : g_slot
      logic [TRI_W-1:0] id;
      assign id     = in_nbr[j*TRI_W +: TRI_W];
      assign adj[j] = (id != NONE) && e_tris[id];
   end

   assign hit = e_vld && (e_qx == in_qx) && (e_qy == in_qy)
              && ((e_cov & in_cov) == 4'b0000) && (|adj);
endmodule

// File: rtl/qm_prio.sv
module qm_prio #(
   parameter int N = 32,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
   assign found = |req;
endmodule

// File: rtl/qm_merge_buf.sv
module qm_merge_buf #(
   parameter int DEPTH = 32,
   parameter int POS_W = 8,
   parameter int TRI_W = 6,
   parameter int NBR_N = 3,
   localparam int MASK_W = 1 << TRI_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [POS_W-1:0]       in_qx,
   input  logic [POS_W-1:0]       in_qy,
   input  logic [3:0]             in_cov,
   input  logic [TRI_W-1:0]       in_tri,
   input  logic [NBR_N*TRI_W-1:0] in_nbr,
   input  logic                   flush,
   output logic                   out_valid,
   output logic [POS_W-1:0]       out_qx,
   output logic [POS_W-1:0]       out_qy,
   output logic [3:0]             out_cov,
   output logic [MASK_W-1:0]      out_tris
);
   import qm_pkg::*;

   localparam int IDX_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   initial begin
      if (DEPTH < 2)  $error("qm_merge_buf: DEPTH must be at least 2");
      if (TRI_W < 2 || TRI_W > 8) $error("qm_merge_buf: TRI_W out of range 2..8");
      if (NBR_N < 1)  $error("qm_merge_buf: NBR_N must be at least 1");
   end

   logic [POS_W-1:0]  e_qx   [DEPTH];
   logic [POS_W-1:0]  e_qy   [DEPTH];
   logic [3:0]        e_cov  [DEPTH];
   logic [MASK_W-1:0] e_tris [DEPTH];
   logic [CNT_W-1:0]  count;

   logic [DEPTH-1:0]  hits;
   logic              hit_any;
   logic [IDX_W-1:0]  hit_idx;
   logic              full;
   logic [MASK_W-1:0] new_mask;
   logic [IDX_W-1:0]  wr_idx;
   qm_act_e           act;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      qm_match #(.POS_W(POS_W), .TRI_W(TRI_W), .NBR_N(NBR_N)) u_match (
         .e_vld  (CNT_W'(i) < count),
         .e_qx   (e_qx[i]),
         .e_qy   (e_qy[i]),
         .e_cov  (e_cov[i]),
         .e_tris (e_tris[i]),
         .in_qx  (in_qx),
         .in_qy  (in_qy),
         .in_cov (in_cov),
         .in_nbr (in_nbr),
         .hit    (hits[i])
      );
   end

   qm_prio #(.N(DEPTH)) u_prio (
      .req   (hits),
      .found (hit_any),
      .idx   (hit_idx)
   );

   assign full     = (count == CNT_W'(DEPTH));
   assign new_mask = MASK_W'(1) << in_tri;
   assign wr_idx   = IDX_W'(count);

   always_comb begin
      if (in_valid) begin
         if (in_cov == 4'b0000) act = ACT_DROP;
         else if (hit_any)      act = ACT_MERGE;
         else if (!full)        act = ACT_APPEND;
         else                   act = ACT_EVICT;
      end else if (flush && count != '0) begin
         act = ACT_DRAIN;
      end else begin
         act = ACT_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count     <= '0;
         out_valid <= 1'b0;
         out_qx    <= '0;
         out_qy    <= '0;
         out_cov   <= '0;
         out_tris  <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            e_qx[i]   <= '0;
            e_qy[i]   <= '0;
            e_cov[i]  <= '0;
            e_tris[i] <= '0;
         end
      end else begin
         out_valid <= (act == ACT_EVICT) || (act == ACT_DRAIN);
         if (act == ACT_EVICT || act == ACT_DRAIN) begin
            out_qx   <= e_qx[0];
            out_qy   <= e_qy[0];
            out_cov  <= e_cov[0];
            out_tris <= e_tris[0];
            for (int i = 0; i < DEPTH - 1; i++) begin
               e_qx[i]   <= e_qx[i+1];
               e_qy[i]   <= e_qy[i+1];
               e_cov[i]  <= e_cov[i+1];
               e_tris[i] <= e_tris[i+1];
            end
         end
         case (act)
            ACT_MERGE: begin
               e_cov[hit_idx]  <= e_cov[hit_idx] | in_cov;
               e_tris[hit_idx] <= e_tris[hit_idx] | new_mask;
            end
            ACT_APPEND: begin
               e_qx[wr_idx]   <= in_qx;
               e_qy[wr_idx]   <= in_qy;
               e_cov[wr_idx]  <= in_cov;
               e_tris[wr_idx] <= new_mask;
               count          <= count + CNT_W'(1);
            end
            ACT_EVICT: begin
               e_qx[DEPTH-1]   <= in_qx;
               e_qy[DEPTH-1]   <= in_qy;
               e_cov[DEPTH-1]  <= in_cov;
               e_tris[DEPTH-1] <= new_mask;
            end
            ACT_DRAIN: count <= count - CNT_W'(1);
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/qm_merge_buf_chk.sv
module qm_merge_buf_chk #(
   parameter int DEPTH  = 32,
   parameter int CNT_W  = 6,
   parameter int MASK_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        in_cov,
   input logic              flush,
   input logic [CNT_W-1:0]  count,
   input logic              out_valid,
   input logic [3:0]        out_cov,
   input logic [MASK_W-1:0] out_tris
);
   p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   p_out_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid || flush));

   p_drain_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && flush && count != '0) |=> (count == $past(count) - CNT_W'(1)));

   p_input_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cov != 4'b0000 && count != '0) |=> (count >= $past(count)));

   p_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cov == 4'b0000) |=> ($stable(count) && !out_valid));

   p_out_cov_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_cov != 4'b0000));

   p_out_tris_r12: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(out_tris) >= 1));
endmodule

bind qm_merge_buf qm_merge_buf_chk #(
   .DEPTH(DEPTH), .CNT_W(CNT_W), .MASK_W(MASK_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cov(in_cov),
   .flush(flush), .count(count), .out_valid(out_valid),
   .out_cov(out_cov), .out_tris(out_tris)
);

// File: tb/qm_merge_buf_bench.sv
`timescale 1ns/1ps
module qm_merge_buf_bench;
   localparam int DEPTH = 32, POS_W = 8, TRI_W = 6, NBR_N = 3, MASK_W = 64;

   logic clk, rst_n, in_valid, flush;
   logic [POS_W-1:0] in_qx, in_qy;
   logic [3:0] in_cov;
   logic [TRI_W-1:0] in_tri;
   logic [NBR_N*TRI_W-1:0] in_nbr;
   logic out_valid;
   logic [POS_W-1:0] out_qx, out_qy;
   logic [3:0] out_cov;
   logic [MASK_W-1:0] out_tris;

   qm_merge_buf #(.DEPTH(DEPTH), .POS_W(POS_W), .TRI_W(TRI_W), .NBR_N(NBR_N)) u_qm_merge_buf (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_qx(in_qx), .in_qy(in_qy),
      .in_cov(in_cov), .in_tri(in_tri), .in_nbr(in_nbr), .flush(flush),
      .out_valid(out_valid), .out_qx(out_qx), .out_qy(out_qy),
      .out_cov(out_cov), .out_tris(out_tris));

   initial clk = 1'b0;
   always #4 clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic [7:0]  mq_x[$], mq_y[$];
   logic [3:0]  mq_c[$];
   logic [63:0] mq_t[$];

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic bit adjacent(logic [63:0] set, logic [5:0] a, logic [5:0] b, logic [5:0] c);
      return (a != 6'h3F && set[a]) || (b != 6'h3F && set[b]) || (c != 6'h3F && set[c]);
   endfunction

   // one cycle: drive at falling edge, one rising edge, compare at next falling edge
   task automatic step(input logic v, input logic [7:0] x, input logic [7:0] y,
                       input logic [3:0] c, input logic [5:0] t,
                       input logic [5:0] n0, input logic [5:0] n1, input logic [5:0] n2,
                       input logic f, input string tag_in);
      logic ev;
      logic [7:0] ex, ey;
      logic [3:0] ec;
      logic [63:0] et;
      string tag;
      int found;
      ev = 0; ex = 0; ey = 0; ec = 0; et = 0;
      tag = tag_in;
      in_valid = v; in_qx = x; in_qy = y; in_cov = c; in_tri = t;
      in_nbr = {n2, n1, n0}; flush = f;
      if (v) begin
         if (c == 4'b0) begin
            if (tag == "") tag = "R11";
         end else begin
            found = -1;
            for (int k = 0; k < mq_x.size(); k++) begin
               if (found < 0 && mq_x[k] == x && mq_y[k] == y && (mq_c[k] & c) == 0
                   && adjacent(mq_t[k], n0, n1, n2)) found = k;
            end
            if (found >= 0) begin
               mq_c[found] = mq_c[found] | c;
               mq_t[found] = mq_t[found] | (64'd1 << t);
               if (tag == "") tag = "R2";
            end else begin
               if (mq_x.size() == DEPTH) begin
                  ev = 1; ex = mq_x.pop_front(); ey = mq_y.pop_front();
                  ec = mq_c.pop_front(); et = mq_t.pop_front();
                  if (tag == "") tag = "R6";
               end else if (tag == "") tag = "R4";
               mq_x.push_back(x); mq_y.push_back(y); mq_c.push_back(c);
               mq_t.push_back(64'd1 << t);
            end
         end
      end else if (f && mq_x.size() > 0) begin
         ev = 1; ex = mq_x.pop_front(); ey = mq_y.pop_front();
         ec = mq_c.pop_front(); et = mq_t.pop_front();
         if (tag == "") tag = "R7";
      end
      if (tag == "") tag = "R7";
      @(posedge clk);
      @(negedge clk);
      chk(tag, "out_valid", 64'(out_valid), 64'(ev));
      if (ev) begin
         chk(tag, "out_qx", 64'(out_qx), 64'(ex));
         chk(tag, "out_qy", 64'(out_qy), 64'(ey));
         chk(tag, "out_cov", 64'(out_cov), 64'(ec));
         chk(tag, "out_tris", out_tris, et);
      end
   endtask

   task automatic put(input logic [7:0] x, input logic [7:0] y, input logic [3:0] c,
                      input logic [5:0] t, input logic [5:0] n0, input logic [5:0] n1,
                      input logic [5:0] n2, input string tag);
      step(1, x, y, c, t, n0, n1, n2, 0, tag);
   endtask

   task automatic drain(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 63, 63, 63, 1, tag);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240917));
      rst_n = 0; in_valid = 0; flush = 0; in_qx = 0; in_qy = 0;
      in_cov = 0; in_tri = 0; in_nbr = '1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "out_valid in reset", 64'(out_valid), 64'd0);
      rst_n = 1;
      drain(2, "R1");

      // R2 merge of neighbours, R12 output fields
      put(1, 1, 4'b0001, 5, 63, 63, 63, "R2");
      put(1, 1, 4'b0010, 6, 5, 63, 63, "R2");
      drain(2, "R12");

      // R3 overlapping coverage stays separate; R7 order
      put(2, 2, 4'b0011, 7, 63, 63, 63, "R3");
      put(2, 2, 4'b0010, 8, 7, 63, 63, "R3");
      drain(3, "R7");

      // R4 not neighbours, or different position
      put(4, 4, 4'b0001, 9, 63, 63, 63, "R4");
      put(4, 4, 4'b0010, 10, 11, 12, 13, "R4");
      put(5, 4, 4'b0100, 11, 9, 63, 63, "R4");
      drain(3, "R4");

      // R5 unused slot code matches nothing, even triangle 63
      put(3, 3, 4'b0001, 63, 63, 63, 63, "R5");
      put(3, 3, 4'b0010, 20, 63, 63, 63, "R5");
      drain(2, "R5");

      // R10 oldest qualifying entry wins
      put(6, 6, 4'b0001, 1, 63, 63, 63, "R10");
      put(6, 6, 4'b0010, 2, 63, 63, 63, "R10");
      put(6, 6, 4'b0100, 3, 2, 1, 63, "R10");
      drain(2, "R10");

      // R8 input beats flush in the same cycle
      step(1, 7, 7, 4'b1000, 30, 63, 63, 63, 1, "R8");
      drain(1, "R8");

      // R11 zero coverage discarded
      put(8, 8, 4'b0000, 31, 63, 63, 63, "R11");
      drain(1, "R11");

      // R6 capacity and eviction, R9 no merge after leaving
      for (int i = 0; i < DEPTH; i++) put(8'(i), 0, 4'b0001, 6'(i), 63, 63, 63, "R6");
      put(100, 0, 4'b0001, 40, 63, 63, 63, "R6");
      put(1, 0, 4'b0010, 41, 0, 63, 63, "R9");
      put(0, 0, 4'b0010, 42, 0, 63, 63, "R9");
      drain(DEPTH + 1, "R9");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic v, f;
         logic [5:0] n0, n1, n2;
         v  = ($urandom % 10) < 7;
         f  = ($urandom % 10) < 2;
         n0 = (($urandom % 10) < 7) ? 6'($urandom % 16) : 6'h3F;
         n1 = (($urandom % 10) < 5) ? 6'($urandom % 16) : 6'h3F;
         n2 = (($urandom % 10) < 3) ? 6'($urandom % 64) : 6'h3F;
         step(v, 8'($urandom % 3), 8'($urandom % 3), 4'($urandom), 6'($urandom % 16),
              n0, n1, n2, f, "");
      end
      drain(DEPTH + 1, "R7");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule